// File: doc/BRIEF.md
# Cache Victim Way Selector

This block picks which way of a set-associative cache is refilled when an access misses. The surrounding cache controller presents the set being accessed together with that set's per-way valid bits. It pulses `hit` with the matching way on a hit, or pulses `miss` when no way matched. On a miss the selector registers the chosen way on `victim`, and the controller fills that way with the incoming block. Tag storage, data arrays and the memory port belong to the controller, not to this block.

A parameter chooses the replacement policy at build time. Random mode uses one free-running counter shared by every set. First-in-first-out mode keeps a per-set pointer to the oldest way. Least-recently-used mode keeps a per-set recency order, which shrinks to a single bit per set when there are two ways. In every mode an empty (invalid) way is preferred over evicting live data. With one way the block always answers way 0.

Top module: `repl_way_sel`

## Requirements
- R1: A synchronous active-high reset sets `victim` to 0 and clears the random counter and every FIFO pointer to 0. It sets each LRU order so that way 0 is the oldest and way WAYS-1 the youngest. A miss right after reset with all ways valid therefore selects way 0 in the FIFO and LRU modes.
- R2: On a miss where any bit of `set_valid` is 0 (bit w is way w), the victim is the lowest-numbered way whose valid bit is 0, in every policy.
- R3: In random mode one counter, shared by all sets, counts 0,1,...,WAYS-1,0,... and advances on every clock edge out of reset. On a miss with all ways valid, the victim is the counter value in the cycle of the miss.
- R4: In FIFO mode each set has its own pointer, starting at 0. The pointer advances by one, wrapping at WAYS-1, on each miss to that set and on nothing else. On a miss with all ways valid, the victim is the pointer of the addressed set.
- R5: In LRU mode with more than two ways, a hit makes the hit way the youngest, and every way younger than it moves one step older. On a miss with all ways valid, the oldest way of the set is the victim.
- R6: In LRU mode the way filled on a miss counts as used and becomes the youngest of its set.
- R7: With two ways in LRU mode, each set keeps one bit naming the less recently used way. The victim is the way not touched most recently.
- R8: With one way (direct mapped) the victim is always way 0.
- R9: `victim` is registered. It changes in the cycle after a miss and otherwise holds its value, whether or not hits occur.
- R10: If `hit` and `miss` are both high in one cycle, the miss is processed and the hit has no effect on the policy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_idx | input | SET_W | Set addressed in this cycle |
| hit | input | 1 | Access hit in way `hit_way` |
| hit_way | input | WAY_W | Way that hit |
| miss | input | 1 | Access missed; select and record a victim |
| set_valid | input | WAYS | Valid bits of the addressed set, bit w is way w |
| victim | output | WAY_W | Way chosen by the most recent miss |

## Verification
Five instances run on the same stimulus: four-way LRU, FIFO and random, two-way LRU, and one-way. Runs of back-to-back misses to one set separate FIFO rotation from LRU behaviour, where a fill counts as a use. Hits placed between misses show LRU reordering while the FIFO pointers stay put. Misses spaced by varying idle gaps show that the random counter advances every cycle and not only on misses. Valid masks with holes in different positions check that the invalid-way preference overrides every policy. A cycle with hit and miss together checks that the miss takes priority.

// File: rtl/repl_pkg.sv
package repl_pkg;

  typedef enum logic [1:0] {
    POL_RANDOM = 2'd0,
    POL_FIFO   = 2'd1,
    POL_LRU    = 2'd2
  } repl_policy_e;

  // index width that never collapses to zero bits
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/repl_first_free.sv
module repl_first_free #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid,
  output logic             any_free,
  output logic [WAY_W-1:0] free_way
);
  // scan from the top down so the lowest empty way wins
  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/repl_rand_ctr.sv
module repl_rand_ctr #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WAY_W-1:0] cnt
);
  localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/repl_fifo_ptrs.sv
module repl_fifo_ptrs #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WAY_W = 2,
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic             adv,
  output logic [WAY_W-1:0] oldest
);
  localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] ptr_q [SETS];

  assign oldest = ptr_q[set_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv) begin
      ptr_q[set_idx] <= (oldest == LAST) ? '0 : oldest + 1'b1;
    end
  end
endmodule

// File: rtl/repl_lru_order.sv
module repl_lru_order #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WAY_W = 2,
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] lru_way
);
  generate
    if (WAYS == 2) begin : g_bit
      // one bit per set naming the less recently used way
      logic old_q [SETS];

      assign lru_way = WAY_W'(old_q[set_idx]);

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SETS; s++) old_q[s] <= 1'b0;
        end else if (touch) begin
          old_q[set_idx] <= ~touch_way[0];
        end
      end
    end else begin : g_age
      // rank per way: 0 is the oldest, WAYS-1 the youngest
      localparam logic [WAY_W-1:0] YOUNG = WAY_W'(WAYS - 1);

      logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
      logic [WAYS-1:0][WAY_W-1:0] cur, nxt;
      logic [WAY_W-1:0]           t_age;

      assign cur   = age_q[set_idx];
      assign t_age = cur[touch_way];

      always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
          if (cur[w] == '0) lru_way = WAY_W'(w);
          if (WAY_W'(w) == touch_way) nxt[w] = YOUNG;
          else if (cur[w] > t_age)    nxt[w] = cur[w] - 1'b1;
          else                        nxt[w] = cur[w];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
        end else if (touch) begin
          age_q[set_idx] <= nxt;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/repl_way_sel.sv
module repl_way_sel
  import repl_pkg::*;
#(
  parameter int           WAYS   = 4,
  parameter int           SETS   = 16,
  parameter repl_policy_e POLICY = POL_LRU,
  localparam int          WAY_W  = idx_w(WAYS),
  localparam int          SET_W  = idx_w(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic             hit,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             miss,
  input  logic [WAYS-1:0]  set_valid,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] victim_d;

  generate
    if (WAYS == 1) begin : g_direct
      assign victim_d = '0;
    end else begin : g_assoc
      logic             any_free;
      logic [WAY_W-1:0] free_way;
      logic [WAY_W-1:0] pol_way;

      repl_first_free #(.WAYS(WAYS), .WAY_W(WAY_W)) u_free (
        .valid(set_valid), .any_free(any_free), .free_way(free_way)
      );

      if (POLICY == POL_RANDOM) begin : g_rand
        repl_rand_ctr #(.WAYS(WAYS), .WAY_W(WAY_W)) u_ctr (
          .clk(clk), .rst(rst), .cnt(pol_way)
        );
      end else if (POLICY == POL_FIFO) begin : g_fifo
        repl_fifo_ptrs #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W),
                         .SET_W(SET_W)) u_ptrs (
          .clk(clk), .rst(rst), .set_idx(set_idx), .adv(miss),
          .oldest(pol_way)
        );
      end else begin : g_lru
        logic             touch;
        logic [WAY_W-1:0] touch_way;
        // a miss fill is a use; a simultaneous hit is dropped
        assign touch     = miss | hit;
        assign touch_way = miss ? victim_d : hit_way;

        repl_lru_order #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W),
                         .SET_W(SET_W)) u_order (
          .clk(clk), .rst(rst), .set_idx(set_idx), .touch(touch),
          .touch_way(touch_way), .lru_way(pol_way)
        );
      end

      assign victim_d = any_free ? free_way : pol_way;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       victim <= '0;
    else if (miss) victim <= victim_d;
  end
endmodule

// File: rtl/repl_way_sel_chk.sv
module repl_way_sel_chk
  import repl_pkg::*;
#(
  parameter int           WAYS   = 4,
  parameter int           SETS   = 16,
  parameter repl_policy_e POLICY = POL_LRU,
  localparam int          WAY_W  = idx_w(WAYS),
  localparam int          SET_W  = idx_w(SETS)
) (
  input logic             clk,
  input logic             rst,
  input logic [SET_W-1:0] set_idx,
  input logic             hit,
  input logic [WAY_W-1:0] hit_way,
  input logic             miss,
  input logic [WAYS-1:0]  set_valid,
  input logic [WAY_W-1:0] victim
);
  localparam bit POW2 = (WAYS & (WAYS - 1)) == 0;

  logic [WAYS-1:0] sv_d;
  logic [WAYS-1:0] below;

  always_ff @(posedge clk) sv_d <= set_valid;
  assign below = WAYS'((1 << victim) - 1);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(miss) |-> $stable(victim));

  a_r2_free_first: assert property (@(posedge clk) disable iff (rst)
    (miss && !(&set_valid)) |=> (!sv_d[victim] && ((sv_d & below) == below)));

  generate
    if (WAYS == 1) begin : g_dm
      a_r8_way_zero: assert property (@(posedge clk) disable iff (rst)
        victim == '0);
    end
    if (WAYS > 1 && POLICY == POL_LRU) begin : g_lru
      a_r5_hit_protects: assert property (@(posedge clk) disable iff (rst)
        ($past(hit) && !$past(miss) && miss && (set_idx == $past(set_idx))
         && (&set_valid)) |=> (victim != $past(hit_way, 2)));
      a_r6_fill_is_use: assert property (@(posedge clk) disable iff (rst)
        (miss && $past(miss) && (set_idx == $past(set_idx)) && (&set_valid)
         && (&$past(set_valid))) |=> (victim != $past(victim)));
    end
    if (WAYS > 1 && POW2 && POLICY == POL_FIFO) begin : g_fifo
      a_r4_rotate: assert property (@(posedge clk) disable iff (rst)
        (miss && $past(miss) && (set_idx == $past(set_idx)) && (&set_valid)
         && (&$past(set_valid))) |=> (victim == $past(victim) + 1'b1));
    end
    if (WAYS > 1 && POW2 && POLICY == POL_RANDOM) begin : g_rand
      a_r3_each_cycle: assert property (@(posedge clk) disable iff (rst)
        (miss && $past(miss) && (&set_valid) && (&$past(set_valid)))
        |=> (victim == $past(victim) + 1'b1));
    end
  endgenerate
endmodule

bind repl_way_sel repl_way_sel_chk #(.WAYS(WAYS), .SETS(SETS), .POLICY(POLICY))
  u_chk (.*);

// File: tb/repl_way_sel_test.sv
module repl_way_sel_test;
  import repl_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] set_idx = '0;
  logic       hit = 1'b0;
  logic [1:0] hit_way = '0;
  logic       miss = 1'b0;
  logic [3:0] set_valid = '0;
  logic [1:0] v_lru, v_fifo, v_rand;
  logic       v_two, v_dm;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  repl_way_sel #(.WAYS(4), .SETS(16), .POLICY(POL_LRU)) uut (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit(hit), .hit_way(hit_way),
    .miss(miss), .set_valid(set_valid), .victim(v_lru));
  repl_way_sel #(.WAYS(4), .SETS(16), .POLICY(POL_FIFO)) u_fifo (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit(hit), .hit_way(hit_way),
    .miss(miss), .set_valid(set_valid), .victim(v_fifo));
  repl_way_sel #(.WAYS(4), .SETS(16), .POLICY(POL_RANDOM)) u_rand (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit(hit), .hit_way(hit_way),
    .miss(miss), .set_valid(set_valid), .victim(v_rand));
  repl_way_sel #(.WAYS(2), .SETS(16), .POLICY(POL_LRU)) u_two (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit(hit), .hit_way(hit_way[0]),
    .miss(miss), .set_valid(set_valid[1:0]), .victim(v_two));
  repl_way_sel #(.WAYS(1), .SETS(16), .POLICY(POL_LRU)) u_dm (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit(hit), .hit_way(1'b0),
    .miss(miss), .set_valid(set_valid[0]), .victim(v_dm));

  // reference state built from the requirements
  int rcnt;
  int fptr [16];
  int age4 [16][4];
  int old2 [16];
  int e_lru, e_fifo, e_rand, e_two;

  always @(posedge clk) begin
    if (rst) rcnt <= 0;
    else     rcnt <= (rcnt + 1) % 4;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic models_reset();
    for (int s = 0; s < 16; s++) begin
      fptr[s] = 0;
      old2[s] = 0;
      for (int w = 0; w < 4; w++) age4[s][w] = w;
    end
  endtask

  task automatic lru_touch(input int s, input int w);
    int a = age4[s][w];
    for (int k = 0; k < 4; k++) begin
      if (k == w)             age4[s][k] = 3;
      else if (age4[s][k] > a) age4[s][k] = age4[s][k] - 1;
    end
  endtask

  function automatic int lowest_free(input logic [3:0] v, input int n);
    for (int w = 0; w < n; w++) if (!v[w]) return w;
    return -1;
  endfunction

  // one miss (optionally with a concurrent hit); starts and ends at a negedge
  task automatic do_miss(input int s, input logic [3:0] v, input bit with_hit,
                         input int hw, input string note);
    int f4 = lowest_free(v, 4);
    int f2 = lowest_free(v, 2);
    string t4 = (f4 >= 0) ? "R2" : "";
    e_lru = 0;
    for (int k = 0; k < 4; k++) if (age4[s][k] == 0) e_lru = k;
    e_fifo = fptr[s];
    e_rand = rcnt;
    e_two  = old2[s];
    if (f4 >= 0) begin e_lru = f4; e_fifo = f4; e_rand = f4; end
    if (f2 >= 0) e_two = f2;
    set_idx = 4'(s); set_valid = v; miss = 1'b1;
    hit = with_hit; hit_way = 2'(hw);
    @(posedge clk);
    fptr[s] = (fptr[s] + 1) % 4;
    lru_touch(s, e_lru);
    old2[s] = 1 - e_two;
    @(negedge clk);
    miss = 1'b0; hit = 1'b0;
    check(v_lru == 2'(e_lru),  {note, " R5/R6 lru4 ", t4}, v_lru, e_lru);
    check(v_fifo == 2'(e_fifo), {note, " R4 fifo ", t4}, v_fifo, e_fifo);
    check(v_rand == 2'(e_rand), {note, " R3 rand ", t4}, v_rand, e_rand);
    check(v_two == 1'(e_two),  {note, " R7 two-way"}, v_two, e_two);
    check(v_dm == 1'b0,        {note, " R8 direct"}, v_dm, 0);
  endtask

  task automatic do_hit(input int s, input int w);
    set_idx = 4'(s); hit = 1'b1; hit_way = 2'(w);
    @(posedge clk);
    lru_touch(s, w);
    if (w < 2) old2[s] = 1 - w;
    @(negedge clk);
    hit = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    models_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(v_lru == 0 && v_fifo == 0 && v_rand == 0, "R1 victim after reset",
          {v_lru, v_fifo, v_rand}, 0);
    rst = 1'b0;
    do_miss(0, 4'hF, 0, 0, "R1 first miss");
    check(v_lru == 0, "R1 lru way0 oldest", v_lru, 0);
    check(v_fifo == 0, "R1 fifo pointer zero", v_fifo, 0);
  endtask

  task automatic t_invalid();
    do_miss(3, 4'b1011, 0, 0, "R2 hole at 2");
    check(v_fifo == 2, "R2 lowest invalid", v_fifo, 2);
    do_miss(3, 4'b0000, 0, 0, "R2 all empty");
    do_miss(3, 4'b0111, 0, 0, "R2 hole at 3");
    check(v_lru == 3, "R2 lowest invalid top", v_lru, 3);
  endtask

  task automatic t_fifo();
    for (int i = 0; i < 5; i++) do_miss(5, 4'hF, 0, 0, "R4 rotate set5");
    do_hit(5, 2);
    do_miss(6, 4'hF, 0, 0, "R4 other set");
    check(v_fifo == 0, "R4 independent set", v_fifo, 0);
    do_miss(5, 4'hF, 0, 0, "R4 hit ignored");
    check(v_fifo == 1, "R4 pointer after wrap", v_fifo, 1);
  endtask

  task automatic t_lru();
    do_hit(9, 2);
    do_hit(9, 0);
    do_miss(9, 4'hF, 0, 0, "R5 after hits");
    check(v_lru == 1, "R5 oldest way", v_lru, 1);
    for (int i = 0; i < 4; i++) do_miss(8, 4'hF, 0, 0, "R6 fills");
    do_hit(8, 0);
    do_miss(8, 4'hF, 0, 0, "R6 fill made young");
    check(v_lru == 1, "R6 victim after fills", v_lru, 1);
  endtask

  task automatic t_two();
    do_hit(10, 0);
    do_miss(10, 4'hF, 0, 0, "R7 after hit 0");
    check(v_two == 1, "R7 untouched way", v_two, 1);
    do_miss(10, 4'hF, 0, 0, "R7 after fill");
    check(v_two == 0, "R7 alternate", v_two, 0);
  endtask

  task automatic t_rand();
    for (int g = 0; g < 4; g++) begin
      idle(g);
      do_miss(11, 4'hF, 0, 0, "R3 gap");
    end
  endtask

  task automatic t_hold();
    logic [1:0] a = v_lru, b = v_fifo, c = v_rand;
    do_hit(12, 3);
    idle(5);
    check(v_lru == a, "R9 lru held", v_lru, a);
    check(v_fifo == b, "R9 fifo held", v_fifo, b);
    check(v_rand == c, "R9 rand held", v_rand, c);
  endtask

  task automatic t_both();
    do_miss(13, 4'hF, 1, 0, "R10 miss with hit");
    check(v_lru == 0, "R10 miss wins", v_lru, 0);
    do_miss(13, 4'hF, 0, 0, "R10 hit dropped");
    check(v_lru == 1, "R10 way0 not refreshed by hit", v_lru, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_invalid();
    t_fifo();
    t_lru();
    t_two();
    t_rand();
    t_hold();
    t_both();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule